// File: doc/BRIEF.md
# Order-statistic CFAR target detector

This block screens a stream of unsigned range-cell magnitudes for targets. Each accepted sample moves a window forward by one cell. The cell in the middle is the cell under test. It is separated from the reference cells by guard cells. Eight reference cells sit on each side of it, sixteen in all.

The noise level is one ranked sample of those sixteen reference cells, not their mean. To find the K-th smallest, the block takes the maximum of the reference set N+1-K times. After each pass it masks the winning entry. The result Z is multiplied by a fixed-point scale factor to form the threshold, and the cell under test is flagged when it exceeds that threshold.

An upstream stage supplies samples through a valid/ready handshake and marks the first cell of each frame. A configuration port sets the rank and the scale factor. For every cell that can be evaluated, the block returns one result pulse carrying the detection bit and the cell index.

Top module: `os_cfar_detector`

## Requirements
- R1: For the cell with index c, the reference cells are the samples at c-9..c-2 and c+2..c+9. The samples at c-1 and c+1 are guard cells and are never ranked. The cell itself is never ranked.
- R2: The noise statistic Z is the K-th smallest of the 16 reference values. K=1 gives the minimum and K=16 gives the maximum. Z is obtained as the (17-K)-th largest value.
- R3: Each maximum is found by a reduction tree of 15 two-input comparators. Equal values resolve to the lowest window position. An entry that is already masked never wins while an unmasked entry remains.
- R4: Each ranking pass masks exactly one reference entry. A cell uses exactly 17-K passes.
- R5: The threshold is (Z × alpha) >> 4. Alpha is an 8-bit unsigned scale with 4 fractional bits, so 16 means 1.0, and the product is kept at its full 16 bits before the shift. out_hit is 1 only when the cell value is strictly greater than the threshold. A cell equal to the threshold gives 0.
- R6: In a frame of L samples, results are produced only for cell indices 9..L-10, each exactly once. No cell nearer an edge ever produces a result or a detection.
- R7: A sample accepted with in_sof=1 becomes index 0 of a new frame. No sample from an earlier frame reaches any decision in the new frame. After reset, the first sample is index 0.
- R8: in_ready drops in the cycle after a sample that completes a window is accepted. out_valid is a one-cycle pulse that appears exactly 18-K clock edges after the accepting edge, which is at most 17 cycles per cell.
- R9: A configured rank of 0 is treated as K=1. A rank above 16 is treated as K=16.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 8 | Unsigned magnitude of one range cell |
| in_sof | input | 1 | Sample is the first of a new frame |
| cfg_rank | input | 5 | Rank K (1 = smallest), sampled when a cell starts ranking |
| cfg_alpha | input | 8 | Threshold scale, 4 fractional bits |
| out_valid | output | 1 | One-cycle result pulse |
| out_hit | output | 1 | Detection for the reported cell |
| out_index | output | 12 | Index of the reported cell within its frame |

## Verification
Frames of four kinds are compared, cell by cell, against a sorting model.

- **Sparse noise with strong targets.** Separates correct rank selection from an off-by-one rank, because a target sitting in a reference cell changes Z only at high K.
- **Constant frame.** Every comparison is a tie. Alpha of exactly 1.0 lands the cell on the threshold, which exposes a non-strict compare. Alpha just under 1.0 must flag every evaluated cell.
- **Ramp and clutter-step frames.** These change the ranked statistic differently at each rank. Ranks outside 1..16 must match the clamped rank.
- **Two adjacent targets.** These prove that guard cells and the cell itself are left out of ranking.
- **Directed tests.** Exact result latency confirms the pass count. Absence checks at frame edges confirm the edge rule. A truncated frame followed by a new frame start confirms the flush.

// File: rtl/cfar_pkg.sv
package cfar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RANK = 2'd1,
    ST_EMIT = 2'd2
  } cfar_state_e;
endpackage

// File: rtl/cfar_window.sv
// Sliding range window. The outputs show the window as it will look after
// the current sample is shifted in, so ranking can start on the same edge.
module cfar_window #(
  parameter int W     = 8,
  parameter int NSIDE = 8,
  parameter int GUARD = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shift_en,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               cut_nxt,
  output logic [2*NSIDE-1:0][W-1:0]  ref_nxt
);
  localparam int HALF = NSIDE + GUARD;
  localparam int NW   = 2 * HALF + 1;

  logic [NW-1:0][W-1:0] win;
  logic [NW-1:0][W-1:0] nxt;

  always_comb begin
    nxt[0] = din;
    for (int j = 1; j < NW; j++) nxt[j] = win[j-1];
  end

  always_ff @(posedge clk) begin
    if (rst)           win <= '0;
    else if (shift_en) win <= nxt;
  end

  assign cut_nxt = nxt[HALF];

  // Leading references are the newest samples. Lagging references lie past
  // the far guard cells.
  for (genvar i = 0; i < NSIDE; i++) begin : g_ref
    assign ref_nxt[i]         = nxt[i];
    assign ref_nxt[NSIDE + i] = nxt[HALF + GUARD + 1 + i];
  end

  // R8: the window does not move while no sample is taken
  p_window_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(win));
endmodule

// File: rtl/cfar_max_tree.sv
// Balanced max reduction with (padded N)-1 comparators. Ties keep the left
// operand, which always covers lower indices.
module cfar_max_tree #(
  parameter int KW = 9,
  parameter int N  = 16
) (
  input  logic [N-1:0][KW-1:0]    keys,
  output logic [KW-1:0]           max_key,
  output logic [$clog2(N)-1:0]    max_idx
);
  localparam int LV    = $clog2(N);
  localparam int NP    = 1 << LV;
  localparam int NODES = 2 * NP - 1;
  localparam int IW    = (LV > 0) ? LV : 1;

  logic [KW-1:0] nk [NODES];
  logic [IW-1:0] ni [NODES];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nk[NP-1+i] = keys[i];
    end else begin : g_pad
      assign nk[NP-1+i] = '0;
    end
    assign ni[NP-1+i] = IW'(i);
  end

  for (genvar k = 0; k < NP - 1; k++) begin : g_cmp
    logic take_right;
    assign take_right = nk[2*k+2] > nk[2*k+1];
    assign nk[k] = take_right ? nk[2*k+2] : nk[2*k+1];
    assign ni[k] = take_right ? ni[2*k+2] : ni[2*k+1];
  end

  assign max_key = nk[0];
  assign max_idx = ni[0][$clog2(N)-1:0];
endmodule

// File: rtl/os_cfar_detector.sv
module os_cfar_detector #(
  parameter int W     = 8,
  parameter int AW    = 8,
  parameter int FRAC  = 4,
  parameter int NSIDE = 8,
  parameter int GUARD = 1,
  parameter int IDXW  = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [W-1:0]                      in_data,
  input  logic                              in_sof,
  input  logic [$clog2(2*NSIDE+1)-1:0]      cfg_rank,
  input  logic [AW-1:0]                     cfg_alpha,
  output logic                              out_valid,
  output logic                              out_hit,
  output logic [IDXW-1:0]                   out_index
);
  import cfar_pkg::*;

  localparam int NREF = 2 * NSIDE;
  localparam int HALF = NSIDE + GUARD;
  localparam int RW   = $clog2(NREF + 1);
  localparam int TW   = $clog2(NREF);
  localparam int KW   = W + 1;
  localparam int PW   = W + AW;

  cfar_state_e state;
  logic [IDXW-1:0]            n_q, n_nxt;
  logic                       accept, eval;
  logic [W-1:0]               cut_nxt, cut_q;
  logic [NREF-1:0][W-1:0]     ref_nxt, ref_q;
  logic [NREF-1:0]            mask;
  logic [NREF-1:0][KW-1:0]    keys;
  logic [KW-1:0]              tkey;
  logic [TW-1:0]              tidx;
  logic [RW-1:0]              k_eff, pass_q, pass_last;
  logic [W-1:0]               z_q;
  logic [AW-1:0]              alpha_q;
  logic [IDXW-1:0]            idx_q;
  logic [PW-1:0]              prod, thr;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign n_nxt    = in_sof ? IDXW'(1) : ((&n_q) ? n_q : n_q + IDXW'(1));
  assign eval     = n_nxt > IDXW'(2 * HALF);

  assign k_eff = (cfg_rank == '0) ? RW'(1) :
                 (cfg_rank > RW'(NREF)) ? RW'(NREF) : cfg_rank;

  cfar_window #(.W(W), .NSIDE(NSIDE), .GUARD(GUARD)) u_win (
    .clk(clk), .rst(rst), .shift_en(accept), .din(in_data),
    .cut_nxt(cut_nxt), .ref_nxt(ref_nxt)
  );

  // Masked entries get a zero top bit and lose to every live entry.
  for (genvar i = 0; i < NREF; i++) begin : g_key
    assign keys[i] = {~mask[i], ref_q[i]};
  end

  cfar_max_tree #(.KW(KW), .N(NREF)) u_tree (
    .keys(keys), .max_key(tkey), .max_idx(tidx)
  );

  assign prod = PW'(z_q) * PW'(alpha_q);
  assign thr  = prod >> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      n_q       <= '0;
      ref_q     <= '0;
      cut_q     <= '0;
      mask      <= '0;
      pass_q    <= '0;
      pass_last <= '0;
      z_q       <= '0;
      alpha_q   <= '0;
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_index <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          n_q <= n_nxt;
          if (eval) begin
            ref_q     <= ref_nxt;
            cut_q     <= cut_nxt;
            mask      <= '0;
            pass_q    <= '0;
            pass_last <= RW'(NREF) - k_eff;
            alpha_q   <= cfg_alpha;
            idx_q     <= n_nxt - IDXW'(1 + HALF);
            state     <= ST_RANK;
          end
        end
        ST_RANK: begin
          mask[tidx] <= 1'b1;
          if (pass_q == pass_last) begin
            z_q   <= tkey[W-1:0];
            state <= ST_EMIT;
          end else begin
            pass_q <= pass_q + RW'(1);
          end
        end
        ST_EMIT: begin
          out_valid <= 1'b1;
          out_hit   <= PW'(cut_q) > thr;
          out_index <= idx_q;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: every ranking pass adds exactly one masked entry
  p_one_mask_per_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RANK) |=> ($countones(mask) == $past($countones(mask)) + 1));

  // R3: the tree never picks an entry that is already masked
  p_winner_live_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RANK) |-> !mask[tidx]);

  // R8: results are single-cycle pulses
  p_result_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: no result is reported for a leading-edge cell
  p_edge_index_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_index >= IDXW'(HALF)));
endmodule

// File: tb/sim_os_cfar_detector.sv
module sim_os_cfar_detector;
  localparam int W = 8, AW = 8, FRAC = 4, NSIDE = 8, GUARD = 1, IDXW = 12;
  localparam int NREF = 2 * NSIDE;
  localparam int HALF = NSIDE + GUARD;
  localparam int L = 40;
  localparam int NV = 11;
  // pattern, rank, alpha
  localparam int TBL [NV][3] = '{
    '{0, 12, 48}, '{0, 16, 40}, '{0, 1, 64}, '{1, 8, 16}, '{1, 8, 15},
    '{2, 4, 20},  '{3, 12, 40}, '{0, 0, 40}, '{3, 20, 32}, '{2, 9, 17},
    '{4, 16, 16}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic in_sof = 1'b0;
  logic [4:0] cfg_rank = 5'd1;
  logic [AW-1:0] cfg_alpha = 8'd16;
  logic out_valid, out_hit;
  logic [IDXW-1:0] out_index;

  int tests = 0, fails = 0;
  int fx [L];
  int seen [L];
  int hit [L];
  int lat = 0;
  int exp_lat = 0;

  always #5 clk = ~clk;

  os_cfar_detector #(.W(W), .AW(AW), .FRAC(FRAC), .NSIDE(NSIDE),
                     .GUARD(GUARD), .IDXW(IDXW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .cfg_rank(cfg_rank),
    .cfg_alpha(cfg_alpha), .out_valid(out_valid), .out_hit(out_hit),
    .out_index(out_index)
  );

  always @(posedge clk) begin
    if (in_valid && in_ready) lat <= 0;
    else lat <= lat + 1;
  end

  // Records results and checks the per-cell latency (R4 pass count, R8).
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_index < L) begin
        seen[out_index] = seen[out_index] + 1;
        hit[out_index] = out_hit;
      end
      tests++;
      if (lat != exp_lat) begin
        fails++;
        $display("FAIL R4 R8 latency idx=%0d actual=%0d expected=%0d",
                 out_index, lat, exp_lat);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int pat(int p, int i);
    int v;
    case (p)
      0: begin v = (((i * 73 + 17) ^ (i * i * 5)) % 32) + 5; if (i % 11 == 5) v += 150; end
      1: v = 20;
      2: v = (i * 5) % 256;
      3: begin v = ((i < 20) ? 10 : 120) + (i * 29) % 7; if (i == 14 || i == 27) v += 100; end
      4: v = (i == 20 || i == 21) ? 200 : 10;
      default: v = 0;
    endcase
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic int model_hit(int c, int k, int a);
    int r [NREF];
    int n = 0;
    int kk, z, t;
    for (int d = GUARD + 1; d <= HALF; d++) begin
      r[n] = fx[c - d]; n++;
      r[n] = fx[c + d]; n++;
    end
    for (int x = 0; x < NREF; x++)
      for (int y = 0; y < NREF - 1 - x; y++)
        if (r[y] > r[y+1]) begin t = r[y]; r[y] = r[y+1]; r[y+1] = t; end
    kk = (k < 1) ? 1 : ((k > NREF) ? NREF : k);
    z = r[kk - 1];
    return (fx[c] > ((z * a) >> FRAC)) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv, int c);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cell=%0d actual=%0d expected=%0d", tag, c, act, expv);
    end
  endtask

  task automatic send(int v, bit sof);
    in_data = v[W-1:0];
    in_sof = sof;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
  endtask

  task automatic run_frame(int p, int k, int a, string tag);
    int kk;
    cfg_rank = k[4:0];
    cfg_alpha = a[AW-1:0];
    kk = (k < 1) ? 1 : ((k > NREF) ? NREF : k);
    exp_lat = NREF + 2 - kk;
    for (int i = 0; i < L; i++) begin
      fx[i] = pat(p, i);
      seen[i] = 0;
      hit[i] = 0;
    end
    for (int i = 0; i < L; i++) begin
      send(fx[i], i == 0);
      if (i == 2 * HALF)
        check(in_ready == 1'b0, "R8 busy", int'(in_ready), 0, i - HALF);
    end
    repeat (40) @(negedge clk);
    for (int c = 0; c < L; c++) begin
      if (c >= HALF && c <= L - 1 - HALF) begin
        int e;
        e = model_hit(c, k, a);
        check(seen[c] == 1, "R6 count", seen[c], 1, c);
        check(hit[c] == e, tag, hit[c], e, c);
      end else begin
        check(seen[c] == 0, "R6 edge", seen[c], 0, c);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0, -1);
    check(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1, -1);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      if (TBL[v][1] < 1 || TBL[v][1] > NREF) tag = "R9 clamp";
      else if (TBL[v][0] == 4) tag = "R1 guard";
      else if (TBL[v][0] == 1 && TBL[v][2] == 16) tag = "R5 equal";
      else if (TBL[v][0] == 1) tag = "R3 ties";
      else tag = "R2 rank";
      run_frame(TBL[v][0], TBL[v][1], TBL[v][2], tag);
    end

    // R7: truncated frame of large values, then a fresh frame start
    cfg_rank = 5'd12;
    exp_lat = NREF + 2 - 12;
    for (int i = 0; i < 25; i++) send(250, i == 0);
    repeat (40) @(negedge clk);
    run_frame(0, 12, 48, "R7 flush");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule